// File: doc/BRIEF.md
# Scrambled ROM Read Path

This block turns one logical word read into the lookup and decoding that a scrambled read-only array needs. A requester presents a 13-bit logical word address over a valid/ready handshake. The block works out where that word really lives by passing the address through a small keyed substitution-permutation network. It starts a one-cycle-latency array read at that physical location. In the same cycle it asks an external block-cipher port for a keystream word. The request carries a 64-bit tweak built from a constant nonce and the logical address.

The word read from the array is 39 bits wide: 32 data bits and 7 check bits. Once both that word and the keystream have arrived, the block runs the word backwards through a zero-keyed substitution-permutation network and XORs the keystream into the result. The 39-bit cleartext is returned over a second valid/ready handshake. Only one read is in flight at a time. Error-correction decoding and the cipher itself live outside this block.

Top module: `scr_rom_reader`

## Requirements
- R1: After reset, req_ready is 1 and rsp_valid, rom_en and ks_req_valid are all 0.
- R2: rom_addr is the forward network applied to the logical address. The key is nonce bits [63:51]. Each of the 2 rounds does four steps: (1) XOR with the key; (2) replace each full 4-bit group (bits [3:0], [7:4], [11:8]) through the table 0→C 1→5 2→6 3→B 4→9 5→0 6→A 7→D 8→3 9→E A→F B→8 C→4 D→7 E→1 F→2, leaving the top bit as it is; (3) reverse the bit order; (4) set output bit i to bit 2i and output bit 6+i to bit 2i+1, for i<6, keeping bit 12. After the last round the key is XORed once more.
- R3: ks_tweak equals nonce bits [50:0] in bits [63:13], with the logical address in bits [12:0].
- R4: rsp_data equals ks_rsp_data XOR the inverse network applied to the stored word, with a zero key, 2 rounds and width 39. Each inverse round XORs the key, then sets bit 2i to bit i and bit 2i+1 to bit 19+i for i<19, keeping bit 38. It then reverses the bit order and maps each of the 9 low 4-bit groups back through the inverse of the R2 table.
- R5: The cycle after a request is accepted, rom_en and ks_req_valid are both 1. rom_en stays high for exactly one cycle, and rom_rdata is taken from the cycle after the one in which rom_en is high.
- R6: ks_req_valid stays 1, with ks_tweak unchanged, until a cycle in which ks_req_ready is 1. It is 0 after that cycle.
- R7: rsp_valid rises the cycle after the later of the array word and the keystream response has been taken. A keystream response that comes several cycles late is waited for.
- R8: While a read is outstanding, req_ready is 0 and a new request has no effect. While rsp_ready is 0, rsp_valid stays 1 and rsp_data stays unchanged.
- R9: The cycle after the response handshake, rsp_valid is 0 and req_ready is 1, so reads can follow one after another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Read request present |
| req_ready | output | 1 | Block can accept a request |
| req_addr | input | 13 | Logical word address |
| rsp_valid | output | 1 | Cleartext word available |
| rsp_ready | input | 1 | Requester takes the cleartext |
| rsp_data | output | 39 | Cleartext word (32 data + 7 check bits) |
| rom_en | output | 1 | Array read strobe |
| rom_addr | output | 13 | Physical array address |
| rom_rdata | input | 39 | Stored word, one cycle after rom_en |
| ks_req_valid | output | 1 | Keystream request to cipher port |
| ks_req_ready | input | 1 | Cipher port takes the request |
| ks_tweak | output | 64 | Tweak for the keystream |
| ks_rsp_valid | input | 1 | Keystream word present |
| ks_rsp_data | input | 39 | Low bits of the cipher output |

## Verification
The hardest cases to reach are the ones where the two halves of a read finish at different times. A cipher port can stall its request, answer late, or both, while the array word has already been taken and the array bus now carries unrelated data. The bench holds ks_req_ready low for several cycles and delays the keystream response by a chosen number of cycles. The array model drives a fixed junk pattern whenever no read is due, so a word latched in the wrong cycle shows up as a wrong result. A second request is also held high for the whole busy period while the response is stalled. The result must still belong to the first address.

// File: rtl/scr_pkg.sv
package scr_pkg;

    localparam int NONCE_W = 64;
    localparam int DEPTH   = 8192;
    localparam int ADDR_W  = $clog2(DEPTH);
    localparam int WORD_W  = 39;
    localparam int ROUNDS  = 2;
    localparam int DNON_W  = NONCE_W - ADDR_W;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } rd_state_e;

    typedef struct packed {
        logic rom_issued;
        logic rom_wait;
        logic rom_have;
        logic ks_sent;
        logic ks_have;
    } rd_flags_t;

    function automatic logic [3:0] sbox_fwd(input logic [3:0] v);
        case (v)
            4'h0: return 4'hc;  4'h1: return 4'h5;  4'h2: return 4'h6;  4'h3: return 4'hb;
            4'h4: return 4'h9;  4'h5: return 4'h0;  4'h6: return 4'ha;  4'h7: return 4'hd;
            4'h8: return 4'h3;  4'h9: return 4'he;  4'ha: return 4'hf;  4'hb: return 4'h8;
            4'hc: return 4'h4;  4'hd: return 4'h7;  4'he: return 4'h1;  default: return 4'h2;
        endcase
    endfunction

    function automatic logic [3:0] sbox_inv(input logic [3:0] v);
        case (v)
            4'hc: return 4'h0;  4'h5: return 4'h1;  4'h6: return 4'h2;  4'hb: return 4'h3;
            4'h9: return 4'h4;  4'h0: return 4'h5;  4'ha: return 4'h6;  4'hd: return 4'h7;
            4'h3: return 4'h8;  4'he: return 4'h9;  4'hf: return 4'ha;  4'h8: return 4'hb;
            4'h4: return 4'hc;  4'h7: return 4'hd;  4'h1: return 4'he;  default: return 4'hf;
        endcase
    endfunction

endpackage

// File: rtl/scr_sp_net.sv
module scr_sp_net #(
    parameter int W       = 13,
    parameter int ROUNDS  = 2,
    parameter bit INVERSE = 1'b0
) (
    input  logic [W-1:0] din,
    input  logic [W-1:0] key,
    output logic [W-1:0] dout
);
    localparam int NIB  = W / 4;
    localparam int HALF = W / 2;

    function automatic logic [W-1:0] fwd_round(input logic [W-1:0] x, input logic [W-1:0] k);
        logic [W-1:0] s, r, b;
        s = x ^ k;
        for (int i = 0; i < NIB; i++) s[4*i +: 4] = scr_pkg::sbox_fwd(s[4*i +: 4]);
        for (int i = 0; i < W; i++) r[W-1-i] = s[i];
        b = r;
        for (int i = 0; i < HALF; i++) begin
            b[i]      = r[2*i];
            b[HALF+i] = r[2*i+1];
        end
        return b;
    endfunction

    function automatic logic [W-1:0] inv_round(input logic [W-1:0] x, input logic [W-1:0] k);
        logic [W-1:0] s, r, b;
        s = x ^ k;
        b = s;
        for (int i = 0; i < HALF; i++) begin
            b[2*i]   = s[i];
            b[2*i+1] = s[HALF+i];
        end
        for (int i = 0; i < W; i++) r[W-1-i] = b[i];
        for (int i = 0; i < NIB; i++) r[4*i +: 4] = scr_pkg::sbox_inv(r[4*i +: 4]);
        return r;
    endfunction

    logic [W-1:0] stage [ROUNDS+1];
    assign stage[0] = din;

    generate
        for (genvar g = 0; g < ROUNDS; g++) begin : g_round
            if (INVERSE) begin : g_inv
                assign stage[g+1] = inv_round(stage[g], key);
            end else begin : g_fwd
                assign stage[g+1] = fwd_round(stage[g], key);
            end
        end
    endgenerate

    assign dout = stage[ROUNDS] ^ key;

endmodule

// File: rtl/scr_rd_ctrl.sv
module scr_rd_ctrl
    import scr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    output logic [ADDR_W-1:0] addr_q,
    output logic              rom_en,
    input  logic [WORD_W-1:0] rom_rdata,
    output logic [WORD_W-1:0] word_q,
    output logic              ks_req_valid,
    input  logic              ks_req_ready,
    input  logic              ks_rsp_valid,
    input  logic [WORD_W-1:0] ks_rsp_data,
    output logic [WORD_W-1:0] ks_q,
    output logic              rsp_valid,
    input  logic              rsp_ready
);
    rd_state_e state;
    rd_flags_t fl;
    logic      ks_take;
    logic      rom_ok_next, ks_ok_next;

    assign req_ready    = (state == ST_IDLE);
    assign rsp_valid    = (state == ST_DONE);
    assign rom_en       = (state == ST_RUN) && !fl.rom_issued;
    assign ks_req_valid = (state == ST_RUN) && !fl.ks_sent;
    assign ks_take      = (state == ST_RUN) && fl.ks_sent && !fl.ks_have && ks_rsp_valid;
    assign rom_ok_next  = fl.rom_have || fl.rom_wait;
    assign ks_ok_next   = fl.ks_have || ks_take;

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            fl     <= '0;
            addr_q <= '0;
            word_q <= '0;
            ks_q   <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        addr_q <= req_addr;
                        fl     <= '0;
                        state  <= ST_RUN;
                    end
                end
                ST_RUN: begin
                    if (rom_en) begin
                        fl.rom_issued <= 1'b1;
                        fl.rom_wait   <= 1'b1;
                    end
                    if (fl.rom_wait) begin
                        word_q      <= rom_rdata;
                        fl.rom_have <= 1'b1;
                        fl.rom_wait <= 1'b0;
                    end
                    if (ks_req_valid && ks_req_ready) fl.ks_sent <= 1'b1;
                    if (ks_take) begin
                        ks_q       <= ks_rsp_data;
                        fl.ks_have <= 1'b1;
                    end
                    if (rom_ok_next && ks_ok_next) state <= ST_DONE;
                end
                ST_DONE: begin
                    if (rsp_ready) state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R5: both the array read and the cipher request launch right after acceptance
    p_launch_r5: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> (rom_en && ks_req_valid));

    // R5: array strobe is a single-cycle pulse
    p_rom_pulse_r5: assert property (@(posedge clk) disable iff (rst)
        rom_en |=> !rom_en);

    // R6: cipher request holds until taken
    p_ks_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (ks_req_valid && !ks_req_ready) |=> ks_req_valid);

    // R8: a single read outstanding
    p_one_outstanding_r8: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid || ks_req_valid || rom_en) |-> !req_ready);

endmodule

// File: rtl/scr_rom_reader.sv
module scr_rom_reader
    import scr_pkg::*;
#(
    parameter logic [NONCE_W-1:0] NONCE = 64'h9c41_e2b7_5a0d_3f68
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [ADDR_W-1:0]  req_addr,
    output logic               rsp_valid,
    input  logic               rsp_ready,
    output logic [WORD_W-1:0]  rsp_data,
    output logic               rom_en,
    output logic [ADDR_W-1:0]  rom_addr,
    input  logic [WORD_W-1:0]  rom_rdata,
    output logic               ks_req_valid,
    input  logic               ks_req_ready,
    output logic [NONCE_W-1:0] ks_tweak,
    input  logic               ks_rsp_valid,
    input  logic [WORD_W-1:0]  ks_rsp_data
);
    localparam logic [ADDR_W-1:0] ADDR_KEY  = NONCE[NONCE_W-1 -: ADDR_W];
    localparam logic [DNON_W-1:0] DATA_NONC = NONCE[DNON_W-1:0];

    logic [ADDR_W-1:0] addr_q;
    logic [WORD_W-1:0] word_q, ks_q, word_plain;

    scr_rd_ctrl u_ctrl (
        .clk          (clk),
        .rst          (rst),
        .req_valid    (req_valid),
        .req_ready    (req_ready),
        .req_addr     (req_addr),
        .addr_q       (addr_q),
        .rom_en       (rom_en),
        .rom_rdata    (rom_rdata),
        .word_q       (word_q),
        .ks_req_valid (ks_req_valid),
        .ks_req_ready (ks_req_ready),
        .ks_rsp_valid (ks_rsp_valid),
        .ks_rsp_data  (ks_rsp_data),
        .ks_q         (ks_q),
        .rsp_valid    (rsp_valid),
        .rsp_ready    (rsp_ready)
    );

    scr_sp_net #(.W(ADDR_W), .ROUNDS(ROUNDS), .INVERSE(1'b0)) u_addr_net (
        .din  (addr_q),
        .key  (ADDR_KEY),
        .dout (rom_addr)
    );

    scr_sp_net #(.W(WORD_W), .ROUNDS(ROUNDS), .INVERSE(1'b1)) u_data_net (
        .din  (word_q),
        .key  ('0),
        .dout (word_plain)
    );

    assign ks_tweak = {DATA_NONC, addr_q};
    assign rsp_data = word_plain ^ ks_q;

    // R8: response is held steady under backpressure
    p_rsp_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));

    // R6: tweak does not move while the cipher request waits
    p_tweak_stable_r6: assert property (@(posedge clk) disable iff (rst)
        (ks_req_valid && !ks_req_ready) |=> $stable(ks_tweak));

    // R9: after the response handshake the block is idle again
    p_release_r9: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_ready) |=> (req_ready && !rsp_valid));

endmodule

// File: tb/scr_rom_reader_bench.sv
module scr_rom_reader_bench;
    localparam logic [63:0] NONCE = 64'h9c41_e2b7_5a0d_3f68;
    localparam logic [38:0] JUNK  = 39'h15_dead_beef;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [12:0] req_addr = '0;
    logic        rsp_valid;
    logic        rsp_ready = 1'b0;
    logic [38:0] rsp_data;
    logic        rom_en;
    logic [12:0] rom_addr;
    logic [38:0] rom_rdata;
    logic        ks_req_valid;
    logic        ks_req_ready = 1'b0;
    logic [63:0] ks_tweak;
    logic        ks_rsp_valid = 1'b0;
    logic [38:0] ks_rsp_data = JUNK;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    scr_rom_reader #(.NONCE(NONCE)) u_scr_rom_reader (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
        .rom_en(rom_en), .rom_addr(rom_addr), .rom_rdata(rom_rdata),
        .ks_req_valid(ks_req_valid), .ks_req_ready(ks_req_ready), .ks_tweak(ks_tweak),
        .ks_rsp_valid(ks_rsp_valid), .ks_rsp_data(ks_rsp_data)
    );

    // ---- reference models ----
    function automatic logic [3:0] tb_sb(input logic [3:0] v);
        logic [3:0] t [16] = '{4'hc,4'h5,4'h6,4'hb,4'h9,4'h0,4'ha,4'hd,
                               4'h3,4'he,4'hf,4'h8,4'h4,4'h7,4'h1,4'h2};
        return t[v];
    endfunction

    function automatic logic [3:0] tb_sbi(input logic [3:0] v);
        for (int j = 0; j < 16; j++) if (tb_sb(4'(j)) == v) return 4'(j);
        return 4'h0;
    endfunction

    function automatic logic [63:0] tb_enc(input logic [63:0] x, input logic [63:0] k, input int w);
        logic [63:0] s, r, b;
        for (int rd = 0; rd < 2; rd++) begin
            s = x ^ k;
            for (int n = 0; n < w/4; n++) s[4*n +: 4] = tb_sb(s[4*n +: 4]);
            r = '0;
            for (int i = 0; i < w; i++) r[w-1-i] = s[i];
            b = r;
            for (int i = 0; i < w/2; i++) begin
                b[i] = r[2*i];
                b[w/2+i] = r[2*i+1];
            end
            x = b;
        end
        return x ^ k;
    endfunction

    function automatic logic [63:0] tb_dec(input logic [63:0] x, input int w);
        logic [63:0] b, r;
        for (int rd = 0; rd < 2; rd++) begin
            b = x;
            for (int i = 0; i < w/2; i++) begin
                b[2*i] = x[i];
                b[2*i+1] = x[w/2+i];
            end
            r = '0;
            for (int i = 0; i < w; i++) r[w-1-i] = b[i];
            for (int n = 0; n < w/4; n++) r[4*n +: 4] = tb_sbi(r[4*n +: 4]);
            x = r;
        end
        return x;
    endfunction

    function automatic logic [38:0] rom_fn(input logic [12:0] p);
        logic [38:0] v;
        v = (39'(p) * 39'd2654435) ^ 39'h2a_5c3e_91d7;
        return {v[38:20], v[19:0] ^ {7'(p), 13'(p)}};
    endfunction

    function automatic logic [63:0] ks_fn(input logic [63:0] t);
        return {t[31:0] ^ 32'h9e37_79b9, t[63:32] ^ 32'h7f4a_7c15};
    endfunction

    // array model: one-cycle latency, junk when no read is due
    always @(posedge clk) rom_rdata <= rom_en ? rom_fn(rom_addr) : JUNK;

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic do_read(input logic [12:0] a, input int rdy_dly, input int rsp_dly,
                           input int out_dly, input bit poke);
        logic [63:0] ephys, etw, eks, eclr;
        ephys = tb_enc(64'(a), 64'(NONCE[63:51]), 13);
        etw   = {NONCE[50:0], a};
        eks   = ks_fn(etw) & 64'h7f_ffff_ffff;
        eclr  = tb_dec(64'(rom_fn(ephys[12:0])), 39) ^ eks;

        @(negedge clk);
        check("R9 ready before request", 64'(req_ready), 64'd1);
        req_valid = 1'b1;
        req_addr  = a;
        @(negedge clk);
        req_valid = poke;
        req_addr  = ~a;
        check("R5 rom_en after accept", 64'(rom_en), 64'd1);
        check("R5 ks_req_valid after accept", 64'(ks_req_valid), 64'd1);
        check("R2 physical address", 64'(rom_addr), ephys);
        check("R3 tweak", ks_tweak, etw);
        for (int i = 0; i < rdy_dly; i++) begin
            @(negedge clk);
            check("R6 request held", 64'(ks_req_valid), 64'd1);
            check("R6 tweak held", ks_tweak, etw);
            check("R5 single strobe", 64'(rom_en), 64'd0);
        end
        ks_req_ready = 1'b1;
        @(negedge clk);
        ks_req_ready = 1'b0;
        check("R6 request dropped", 64'(ks_req_valid), 64'd0);
        check("R5 single strobe", 64'(rom_en), 64'd0);
        for (int i = 0; i < rsp_dly; i++) begin
            check("R7 waits for keystream", 64'(rsp_valid), 64'd0);
            check("R8 busy", 64'(req_ready), 64'd0);
            @(negedge clk);
        end
        ks_rsp_valid = 1'b1;
        ks_rsp_data  = eks[38:0];
        @(negedge clk);
        ks_rsp_valid = 1'b0;
        ks_rsp_data  = JUNK;
        check("R7 response valid", 64'(rsp_valid), 64'd1);
        for (int i = 0; i < out_dly; i++) begin
            check("R8 data held", 64'(rsp_data), eclr);
            check("R8 not ready while busy", 64'(req_ready), 64'd0);
            @(negedge clk);
            check("R8 valid held", 64'(rsp_valid), 64'd1);
        end
        check("R4 cleartext", 64'(rsp_data), eclr);
        rsp_ready = 1'b1;
        @(negedge clk);
        rsp_ready = 1'b0;
        req_valid = 1'b0;
        check("R9 valid drops", 64'(rsp_valid), 64'd0);
        check("R9 ready returns", 64'(req_ready), 64'd1);
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 req_ready", 64'(req_ready), 64'd1);
        check("R1 rsp_valid", 64'(rsp_valid), 64'd0);
        check("R1 rom_en", 64'(rom_en), 64'd0);
        check("R1 ks_req_valid", 64'(ks_req_valid), 64'd0);
    endtask

    task automatic t_basic();        do_read(13'h0000, 0, 0, 0, 1'b0); endtask
    task automatic t_slow_cipher();  do_read(13'h1abc, 3, 0, 0, 1'b0); endtask
    task automatic t_late_keystream(); do_read(13'h1fff, 0, 5, 0, 1'b0); endtask
    task automatic t_backpressure(); do_read(13'h0f0f, 2, 1, 4, 1'b1); endtask
    task automatic t_back_to_back();
        for (int k = 0; k < 8; k++) do_read(13'(k * 1031 + 7), k % 2, k % 3, 0, 1'b0);
    endtask

    initial begin
        fork
            begin
                t_reset();
                t_basic();
                t_slow_cipher();
                t_late_keystream();
                t_backpressure();
                t_back_to_back();
            end
            begin
                repeat (20000) @(posedge clk);
                n_chk++;
                n_bad++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        disable fork;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule